// File: doc/BRIEF.md
# Programmable Tick Interrupt Timer

This block produces a periodic interrupt from a slow reference. A single-cycle enable, asserted at 32.768 kHz, drives a free-running prescaler. A 4-bit select field divides that rate by 2^SEL, giving a tick rate of 32768 / 2^SEL Hz. Each prescaled pulse decrements a down-counter. When the counter expires, it reloads from a programmable count, sets a pending flag and raises a level interrupt. Software clears the interrupt by writing one to the pending flag.

Software drives the timer through a small register port with valid, write, address and data. The timer starts only on a control write that turns the tick enable on while the global enable is also on and a usable reload count is present. Any control write that leaves either enable off stops the counter, and the count then holds its value. The live count can be read back at any time.

Top module: `tick_timer`

## Requirements
- R1: The register map uses word addresses: 0 is control, 1 is reload, 2 is pending and 3 is the live count. Control bit 0 is the global enable, bits [7:4] are the select field SEL and bit 8 is the tick enable. A control read returns only those bits, with every other bit reading 0. Any other address reads 0, and writes to it change nothing.
- R2: The prescaler counts every base-enable pulse. A base pulse becomes a prescaled pulse when the low SEL bits of the prescaler, taken before the increment, are all ones. With SEL = 0, every base pulse is a prescaled pulse. A change to SEL applies from the next base pulse on.
- R3: A write to the reload register takes effect only when the low CNT_W bits of the written data exceed 2. Otherwise the previous value stays.
- R4: The counter loads the reload value and starts running on a control write that meets all of these conditions: it sets bit 8 while the stored bit 8 is 0, it sets bit 0, and the reload register is nonzero. In every other case it does not start.
- R5: Any control write with bit 0 or bit 8 cleared stops the counter. A stopped counter holds its value through base pulses.
- R6: On a prescaled pulse, a running counter at 1 expires. On expiry it reloads, sets pending bit 0 and keeps running. Otherwise a running counter decrements by one on each prescaled pulse, so the period is the reload value in prescaled pulses.
- R7: Writing pending bit 0 as 1 clears it, and writing it as 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R8: A read of address 3 returns the current value of the down-counter.
- R9: The interrupt output equals the pending flag, so it stays high until cleared.
- R10: After reset, every register and the count are 0 and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One-cycle enable at 32.768 kHz |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| tick_irq | output | 1 | Level tick interrupt |

## Verification
The bench checks the start gate from several states that must not start the counter:
- a reload of zero;
- the global enable off;
- the tick enable already set when the global enable returns.

A design that starts on the enable level instead of its rising edge would show a moving count in one of these cases.

A reference model of the prescaler phase predicts the count after every base pulse with SEL = 2. This catches a divider that is off by one or tied to the wrong edge.

The bench also covers three boundary writes:
- reload values of 1 and 2, which a design with a wrong threshold would accept;
- a pending-clear write of 0, which a sloppy decoder would act on;
- a clear that coincides with an expiry, which loses the interrupt if the clear wins.

// File: rtl/tick_pkg.sv
package tick_pkg;
  parameter int PRE_W = 15;
  parameter int SEL_W = 4;

  localparam int BIT_GLOBAL = 0;
  localparam int SEL_LSB    = 4;
  localparam int BIT_TICK   = 8;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_PEND   = 2'd2,
    REG_COUNT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             tick_en;
    logic [SEL_W-1:0] sel;
    logic             glob_en;
  } ctrl_t;

  // True when the low 'sel' bits of the prescaler are all ones
  function automatic logic presc_hit(input logic [PRE_W-1:0] c,
                                     input logic [SEL_W-1:0] s);
    logic [PRE_W:0] mask;
    mask = ((PRE_W+1)'(1) << s) - (PRE_W+1)'(1);
    return ({1'b0, c} & mask) == mask;
  endfunction

  // Reload values of 0, 1 and 2 are refused
  function automatic logic reload_ok(input logic [31:0] v);
    return v > 32'd2;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (base_en) pre_q <= pre_q + PRE_W'(1);
  end

  assign tick = base_en && presc_hit(pre_q, sel);

  assert_sel0_every_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_en && sel == '0) |-> tick);
  assert_no_base_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !base_en |=> $stable(pre_q));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              pending_q,
  output logic              start_evt,
  output logic              stop_evt
);
  logic ctrl_wr, reload_wr, pend_clr, reload_take;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign ctrl_wr     = wr_en && (addr == ADDR_W'(REG_CTRL));
  assign reload_wr   = wr_en && (addr == ADDR_W'(REG_RELOAD));
  assign pend_clr    = wr_en && (addr == ADDR_W'(REG_PEND)) && wdata[0];
  assign reload_take = reload_wr && reload_ok(32'(wdata[CNT_W-1:0]));

  assign start_evt = ctrl_wr && wdata[BIT_TICK] && wdata[BIT_GLOBAL]
                     && !ctrl_q.tick_en && (reload_q != '0);
  assign stop_evt  = ctrl_wr && (!wdata[BIT_TICK] || !wdata[BIT_GLOBAL]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.tick_en <= wdata[BIT_TICK];
        ctrl_q.sel     <= wdata[SEL_LSB +: SEL_W];
        ctrl_q.glob_en <= wdata[BIT_GLOBAL];
      end
      if (reload_take) reload_q <= wdata[CNT_W-1:0];
      // an expiry in the same cycle as a clear keeps the flag set
      pending_q <= expire | (pending_q & ~pend_clr);
    end
  end

  assert_reload_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && !reload_take) |=> $stable(reload_q));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !expire) |=> !pending_q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending_q);
  assert_start_stop_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  assign expire = running && tick && !start && !stop && (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (start) begin
      count   <= reload;
      running <= 1'b1;
    end else if (stop) begin
      running <= 1'b0;
    end else if (running && tick) begin
      if (expire) count <= reload;
      else        count <= count - CNT_W'(1);
    end
  end

  assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && count == $past(reload)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));
  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !running);
  assert_keep_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> running);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q, count;
  logic             pending_q, start_evt, stop_evt;
  logic             presc_tick, running, expire, wr_en;

  assign wr_en = bus_valid && bus_write;

  tick_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .base_en(base_en),
    .sel(ctrl_q.sel), .tick(presc_tick)
  );

  tick_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .expire(expire), .ctrl_q(ctrl_q),
    .reload_q(reload_q), .pending_q(pending_q),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(presc_tick), .start(start_evt),
    .stop(stop_evt), .reload(reload_q), .count(count),
    .running(running), .expire(expire)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(REG_CTRL): begin
        bus_rdata[BIT_GLOBAL]          = ctrl_q.glob_en;
        bus_rdata[SEL_LSB +: SEL_W]    = ctrl_q.sel;
        bus_rdata[BIT_TICK]            = ctrl_q.tick_en;
      end
      ADDR_W'(REG_RELOAD): bus_rdata = DATA_W'(reload_q);
      ADDR_W'(REG_PEND):   bus_rdata = DATA_W'(pending_q);
      ADDR_W'(REG_COUNT):  bus_rdata = DATA_W'(count);
      default:             bus_rdata = '0;
    endcase
  end

  assign tick_irq = pending_q;

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> $past(expire));
  assert_run_needs_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (ctrl_q.glob_en && ctrl_q.tick_en));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_en = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic tick_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_rl = 0, m_pend = 0, m_run = 0, m_tick = 0, m_sel = 0, m_pre = 0;

  tick_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_pulse();
    int p;
    p = 1 << m_sel;
    if ((m_pre % p) == p - 1 && m_run != 0) begin
      if (m_cnt <= 1) begin m_cnt = m_rl; m_pend = 1; end
      else m_cnt--;
    end
    m_pre = (m_pre + 1) % 32768;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input bit with_pulse = 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    base_en = with_pulse;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; base_en = 0;
    if (a == 0) begin
      bit nt, ng;
      nt = d[8]; ng = d[0];
      if (nt && ng && m_tick == 0 && m_rl != 0) begin m_cnt = m_rl; m_run = 1; end
      else if (!nt || !ng) m_run = 0;
      m_tick = nt; m_sel = int'(d[7:4]);
    end else if (a == 1) begin
      if (d[CNT_W-1:0] > 2) m_rl = int'(d[CNT_W-1:0]);
    end else if (a == 2) begin
      if (d[0]) m_pend = 0;
    end
    if (with_pulse) model_pulse();
  endtask

  task automatic rd(input int a, output longint v);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1 v = longint'(bus_rdata);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_en = 1;
      @(negedge clk); base_en = 0;
      model_pulse();
    end
  endtask

  task automatic t_reset();
    longint v;
    for (int a = 0; a < 4; a++) begin
      rd(a, v); chk("R10 reset reg", v, 0);
    end
    chk("R10 reset irq", tick_irq, 0);
  endtask

  task automatic t_zero_reload();
    longint v;
    wr(0, 32'h101);
    pulse(3);
    rd(3, v); chk("R4 zero reload no start", v, 0);
    chk("R4 zero reload irq", tick_irq, 0);
    wr(0, 32'h0);
  endtask

  task automatic t_reload();
    longint v;
    wr(1, 2); rd(1, v); chk("R3 reject 2", v, 0);
    wr(1, 1); rd(1, v); chk("R3 reject 1", v, 0);
    wr(1, 3); rd(1, v); chk("R3 accept 3", v, 3);
    wr(1, 0); rd(1, v); chk("R3 reject 0", v, 3);
    wr(1, 7); rd(1, v); chk("R3 accept 7", v, 7);
    wr(9, 32'hFF); rd(9, v); chk("R1 unmapped read", v, 0);
    rd(1, v); chk("R1 unmapped write ignored", v, 7);
  endtask

  task automatic t_start_gate();
    longint v;
    wr(0, 32'h100);
    rd(0, v); chk("R1 ctrl readback", v, 32'h100);
    pulse(2);
    rd(3, v); chk("R4 no start without global", v, 0);
    wr(0, 32'h101);
    pulse(2);
    rd(3, v); chk("R4 no start tick already on", v, 0);
    wr(0, 32'h001);
    wr(0, 32'h101);
    rd(3, v); chk("R4 start loads reload", v, 7);
  endtask

  task automatic t_expire();
    longint v;
    pulse(3);
    rd(3, v); chk("R8 live count", v, 4);
    pulse(3);
    rd(3, v); chk("R6 count at one", v, 1);
    chk("R9 irq low before expiry", tick_irq, 0);
    pulse(1);
    rd(3, v); chk("R6 reload on expiry", v, 7);
    rd(2, v); chk("R6 pending set", v, 1);
    chk("R9 irq high", tick_irq, 1);
    pulse(2);
    rd(3, v); chk("R6 keeps running", v, 5);
  endtask

  task automatic t_w1c();
    longint v;
    wr(2, 0); rd(2, v); chk("R7 write 0 no effect", v, 1);
    chk("R9 irq stays", tick_irq, 1);
    wr(2, 1); rd(2, v); chk("R7 write 1 clears", v, 0);
    chk("R9 irq drops", tick_irq, 0);
    pulse(4);
    rd(3, v); chk("R6 count before collision", v, 1);
    wr(2, 1, 1);
    rd(2, v); chk("R7 expiry beats clear", v, 1);
    rd(3, v); chk("R6 reload at collision", v, 7);
    wr(2, 1);
    chk("R7 cleared again", tick_irq, 0);
  endtask

  task automatic t_presc();
    longint v;
    wr(0, 32'h121);
    rd(0, v); chk("R1 sel readback", v, 32'h121);
    for (int i = 0; i < 14; i++) begin
      pulse(1);
      rd(3, v); chk("R2 sel=2 count", v, m_cnt);
      chk("R2 sel=2 pending", tick_irq, m_pend);
    end
    wr(0, 32'h101);
    pulse(1);
    rd(3, v); chk("R2 sel back to 0", v, m_cnt);
  endtask

  task automatic t_stop();
    longint v, held;
    wr(0, 32'h001);
    rd(3, held);
    pulse(5);
    rd(3, v); chk("R5 hold after tick off", v, held);
    wr(0, 32'h101);
    rd(3, v); chk("R4 restart reloads", v, 7);
    pulse(2);
    wr(0, 32'h100);
    pulse(4);
    rd(3, v); chk("R5 hold after global off", v, 5);
    wr(0, 32'h101);
    pulse(2);
    rd(3, v); chk("R4 no restart without edge", v, 5);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R1 ctrl mask", v, 32'h1F1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_zero_reload();
    t_reload();
    t_start_gate();
    t_expire();
    t_w1c();
    t_presc();
    t_stop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule